// File: doc/BRIEF.md
# I2C Mode Control Register

This block is the 8-bit control register of an I2C controller, together with the hardware that changes it while transfers run. Software reads and writes the register. It holds an interface-enable flag, a reception-hold flag, a master/slave flag, a transmit/receive flag and four general bits that are plain storage. The bus engine reports two events that rewrite the mode flags. Losing arbitration as a master drops the block into slave receive. A slave address byte that matches the block's own address and asks for a read switches it to slave transmit.

The mode flags are kept as a four-state machine `i2c_mode_fsm`. Its states are SLV_RX (00), SLV_TX (01), MST_RX (10) and MST_TX (11), and it has three transitions. T_SW_WRITE loads the state from the written bits. T_ARB_LOSS takes MST_RX or MST_TX to SLV_RX. T_ADDR_READ takes SLV_RX to SLV_TX. A second machine, `i2c_rx_gate`, has the states RX_OPEN and RX_HELD. Its transition T_HOLD moves it to RX_HELD when receive data is read in a receive mode while the hold flag is set. Its transition T_RELEASE moves it back to RX_OPEN once software clears that flag. The pin output enables are gated by the interface-enable flag.

Top module: `i2c_mode_ctrl`

## Requirements
- R1: After reset, `rd_data` is 0x00, `mode` is 00, `rx_next_en` is 1, and both `scl_oe` and `sda_oe` are 0.
- R2: A write with `wr_en`=1 and no hardware event in the same cycle stores all eight bits of `wr_data`, and they read back on `rd_data` from the next cycle. Bit 7 is interface enable, bit 6 is reception hold, bit 5 is master and bit 4 is transmit. Bits 3..0 are plain storage.
- R3: `mode` always equals {`rd_data[5]`, `rd_data[4]`}. The encodings are 00 slave receive, 01 slave transmit, 10 master receive and 11 master transmit.
- R4: `scl_oe` equals `scl_drive` and `sda_oe` equals `sda_drive` when bit 7 is 1. Both are 0 when bit 7 is 0.
- R5: `arb_lost`=1 in mode 10 or 11 sets `mode` to 00 in the next cycle. In mode 00 or 01, `arb_lost` has no effect.
- R6: In mode 00, a pulse on `addr_done` with `addr_match`=1 and `addr_rw`=1 sets `mode` to 01 in the next cycle. With `addr_rw`=0, with `addr_match`=0, or in any other mode, the pulse leaves `mode` unchanged.
- R7: When a hardware event of R5 or R6 occurs in the same cycle as a write, the hardware result sets bits 5..4. Bits 7, 6 and 3..0 still take the written value.
- R8: A pulse on `rxd_read` while bit 4 is 0 and bit 6 is 1 drives `rx_next_en` to 0 from the next cycle. It stays 0 while bit 6 remains 1. It returns to 1 in the cycle after bit 6 reads 0. A pulse on `rxd_read` while bit 6 is 0 or bit 4 is 1 leaves `rx_next_en` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register contents |
| arb_lost | input | 1 | Arbitration lost event from the bus engine |
| addr_done | input | 1 | Slave address byte received strobe |
| addr_match | input | 1 | Received address equals own address |
| addr_rw | input | 1 | Direction bit of the received address byte (1 = read) |
| rxd_read | input | 1 | Receive data register read strobe |
| scl_drive | input | 1 | Bus engine request to pull SCL low |
| sda_drive | input | 1 | Bus engine request to pull SDA low |
| scl_oe | output | 1 | Gated SCL output enable |
| sda_oe | output | 1 | Gated SDA output enable |
| mode | output | 2 | Operating mode {master, transmit} |
| rx_next_en | output | 1 | Next reception allowed |

## Verification
The mode machine is first loaded through each of the four encodings, so that a swapped or stuck mode bit shows up. Arbitration loss is then raised in both master modes and in both slave modes. This separates a correct fall to slave receive from one that clears only one bit or that also fires in slave modes. Address events are sent with a read request, with a write request, with a mismatch, and while the block is a master. These show whether the match, the direction bit and the current mode are each taken into account. Same-cycle write and event collisions, and read strobes sent with each combination of the hold and transmit flags, check the priority rule and both paths out of the hold state.

// File: rtl/i2c_mode_pkg.sv
package i2c_mode_pkg;
    localparam int REG_W    = 8;
    localparam int AUX_W    = 4;
    localparam int BIT_EN   = 7;
    localparam int BIT_HOLD = 6;
    localparam int BIT_MST  = 5;
    localparam int BIT_TRS  = 4;

    typedef enum logic [1:0] {
        SLV_RX = 2'b00,
        SLV_TX = 2'b01,
        MST_RX = 2'b10,
        MST_TX = 2'b11
    } op_mode_e;

    typedef enum logic {
        RX_OPEN = 1'b0,
        RX_HELD = 1'b1
    } rx_state_e;
endpackage

// File: rtl/i2c_mode_fsm.sv
module i2c_mode_fsm
    import i2c_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sw_we,
    input  op_mode_e sw_mode,
    input  logic     arb_lost,
    input  logic     addr_done,
    input  logic     addr_match,
    input  logic     addr_rw,
    output op_mode_e mode_q,
    output logic     is_master,
    output logic     is_tx
);
    op_mode_e nxt;

    // Next-state: software load first, hardware events override it.
    always_comb begin
        nxt = sw_we ? sw_mode : mode_q;
        unique case (mode_q)
            MST_RX, MST_TX: begin
                if (arb_lost) nxt = SLV_RX;                 // T_ARB_LOSS
            end
            SLV_RX: begin
                if (addr_done && addr_match && addr_rw) nxt = SLV_TX; // T_ADDR_READ
            end
            SLV_TX: begin
                nxt = nxt;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= SLV_RX;
        else        mode_q <= nxt;
    end

    always_comb begin
        is_master = (mode_q == MST_RX) || (mode_q == MST_TX);
        is_tx     = (mode_q == SLV_TX) || (mode_q == MST_TX);
    end
endmodule

// File: rtl/i2c_rx_gate.sv
module i2c_rx_gate
    import i2c_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_we,
    input  logic sw_hold,
    input  logic rxd_read,
    input  logic is_tx,
    output logic hold_q,
    output logic next_en
);
    rx_state_e st_q, st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hold_q <= 1'b0;
        else if (sw_we) hold_q <= sw_hold;
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            RX_OPEN: if (rxd_read && !is_tx && hold_q) st_nxt = RX_HELD; // T_HOLD
            RX_HELD: if (!hold_q) st_nxt = RX_OPEN;                     // T_RELEASE
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_OPEN;
        else        st_q <= st_nxt;
    end

    always_comb next_en = (st_q == RX_OPEN);
endmodule

// File: rtl/i2c_cfg_bits.sv
module i2c_cfg_bits #(
    parameter int AUX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic             sw_en,
    input  logic [AUX_W-1:0] sw_aux,
    output logic             en_q,
    output logic [AUX_W-1:0] aux_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            aux_q <= '0;
        end else if (sw_we) begin
            en_q  <= sw_en;
            aux_q <= sw_aux;
        end
    end
endmodule

// File: rtl/i2c_mode_ctrl.sv
module i2c_mode_ctrl
    import i2c_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       arb_lost,
    input  logic       addr_done,
    input  logic       addr_match,
    input  logic       addr_rw,
    input  logic       rxd_read,
    input  logic       scl_drive,
    input  logic       sda_drive,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic [1:0] mode,
    output logic       rx_next_en
);
    op_mode_e         mode_q;
    logic             is_master, is_tx, hold_q, en_q;
    logic [AUX_W-1:0] aux_q;

    i2c_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sw_we(wr_en),
        .sw_mode(op_mode_e'({wr_data[BIT_MST], wr_data[BIT_TRS]})),
        .arb_lost(arb_lost), .addr_done(addr_done),
        .addr_match(addr_match), .addr_rw(addr_rw),
        .mode_q(mode_q), .is_master(is_master), .is_tx(is_tx)
    );

    i2c_rx_gate u_gate (
        .clk(clk), .rst_n(rst_n), .sw_we(wr_en), .sw_hold(wr_data[BIT_HOLD]),
        .rxd_read(rxd_read), .is_tx(is_tx), .hold_q(hold_q), .next_en(rx_next_en)
    );

    i2c_cfg_bits #(.AUX_W(AUX_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .sw_we(wr_en), .sw_en(wr_data[BIT_EN]),
        .sw_aux(wr_data[AUX_W-1:0]), .en_q(en_q), .aux_q(aux_q)
    );

    always_comb begin
        rd_data = {en_q, hold_q, is_master, is_tx, aux_q};
        mode    = mode_q;
        scl_oe  = en_q & scl_drive;
        sda_oe  = en_q & sda_drive;
    end
endmodule

// File: rtl/i2c_mode_ctrl_chk.sv
module i2c_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       arb_lost,
    input logic       addr_done,
    input logic       addr_match,
    input logic       addr_rw,
    input logic       rxd_read,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic [1:0] mode,
    input logic       rx_next_en
);
    AST_MODE_MIRRORS: assert property (@(posedge clk) disable iff (!rst_n)
        mode == rd_data[5:4]); // R3
    AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[7] |-> (!scl_oe && !sda_oe)); // R4
    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !arb_lost && !addr_done) |=> rd_data == $past(wr_data)); // R2
    AST_ARB_TO_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && mode[1]) |=> mode == 2'b00); // R5
    AST_ADDR_READ_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_done && addr_match && addr_rw && mode == 2'b00) |=> mode == 2'b01); // R6
    AST_RX_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (rxd_read && !rd_data[4] && rd_data[6]) |=> !rx_next_en); // R8
    AST_RX_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_next_en && rd_data[6]) |=> !rx_next_en); // R8
endmodule

bind i2c_mode_ctrl i2c_mode_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .arb_lost(arb_lost), .addr_done(addr_done), .addr_match(addr_match),
    .addr_rw(addr_rw), .rxd_read(rxd_read), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .mode(mode), .rx_next_en(rx_next_en)
);

// File: tb/sim_i2c_mode_ctrl.sv
module sim_i2c_mode_ctrl;
    localparam int CLK_PER = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       arb_lost = 1'b0, addr_done = 1'b0, addr_match = 1'b0, addr_rw = 1'b0;
    logic       rxd_read = 1'b0, scl_drive = 1'b0, sda_drive = 1'b0;
    logic       scl_oe, sda_oe, rx_next_en;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;

    i2c_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .arb_lost(arb_lost), .addr_done(addr_done), .addr_match(addr_match),
        .addr_rw(addr_rw), .rxd_read(rxd_read), .scl_drive(scl_drive),
        .sda_drive(sda_drive), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .mode(mode), .rx_next_en(rx_next_en)
    );

    always #(CLK_PER/2) clk = ~clk;

    // Behavioural reference: integer register image plus a blocked flag
    int m_reg = 0;
    int m_blocked = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int nreg, m_bit, t_bit, next_block;
        if (!rst_n) begin
            m_reg = 0;
            m_blocked = 0;
        end else begin
            m_bit = (m_reg / 32) % 2;
            t_bit = (m_reg / 16) % 2;
            nreg  = wr_en ? int'(wr_data) : m_reg;
            if (arb_lost && m_bit == 1)
                nreg = nreg - (nreg % 64) + (nreg % 16);             // mode -> slave receive
            else if (addr_done && addr_match && addr_rw && m_bit == 0 && t_bit == 0)
                nreg = nreg - (nreg % 64) + 16 + (nreg % 16);        // mode -> slave transmit
            if (rxd_read && t_bit == 0 && ((m_reg / 64) % 2) == 1) next_block = 1;
            else if (((m_reg / 64) % 2) == 0) next_block = 0;
            else next_block = m_blocked;
            m_reg = nreg;
            m_blocked = next_block;
        end
        #(CLK_PER/4);
        if (rst_n) begin
            chk("R2 rd_data vs model", int'(rd_data), m_reg);
            chk("R3 mode vs model", int'(mode), (m_reg / 16) % 4);
            chk("R4 scl_oe vs model", int'(scl_oe), (m_reg / 128) * int'(scl_drive));
            chk("R4 sda_oe vs model", int'(sda_oe), (m_reg / 128) * int'(sda_drive));
            chk("R8 rx_next_en vs model", int'(rx_next_en), 1 - m_blocked);
        end
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d; cyc(); wr_en = 1'b0;
    endtask

    task automatic addr_evt(input logic mt, input logic rw);
        addr_done = 1'b1; addr_match = mt; addr_rw = rw; cyc();
        addr_done = 1'b0; addr_match = 1'b0; addr_rw = 1'b0;
    endtask

    task automatic arb();
        arb_lost = 1'b1; cyc(); arb_lost = 1'b0;
    endtask

    initial begin
        #(CLK_PER * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        // R1 reset state
        chk("R1 rd_data", int'(rd_data), 'h00);
        chk("R1 mode", int'(mode), 0);
        chk("R1 rx_next_en", int'(rx_next_en), 1);
        chk("R1 oe", int'({scl_oe, sda_oe}), 0);
        rst_n = 1'b1;
        cyc();

        // R2 full readback
        wr(8'h8A); chk("R2 readback", int'(rd_data), 'h8A);
        wr(8'h05); chk("R2 readback low", int'(rd_data), 'h05);

        // R3 all four encodings
        wr(8'h80); chk("R3 slave rx", int'(mode), 0);
        wr(8'h90); chk("R3 slave tx", int'(mode), 1);
        wr(8'hA0); chk("R3 master rx", int'(mode), 2);
        wr(8'hB0); chk("R3 master tx", int'(mode), 3);

        // R4 output-enable gating
        scl_drive = 1'b1; sda_drive = 1'b1; cyc();
        chk("R4 enabled oe", int'({scl_oe, sda_oe}), 3);
        wr(8'h30); chk("R4 disabled oe", int'({scl_oe, sda_oe}), 0);
        sda_drive = 1'b0; wr(8'h80);
        chk("R4 sda follows", int'({scl_oe, sda_oe}), 2);
        scl_drive = 1'b0;

        // R5 arbitration loss
        wr(8'hA0); arb(); chk("R5 from master rx", int'(mode), 0);
        wr(8'hB3); arb(); chk("R5 from master tx", int'(rd_data), 'h83);
        wr(8'h90); arb(); chk("R5 slave tx untouched", int'(mode), 1);
        wr(8'h80); arb(); chk("R5 slave rx untouched", int'(mode), 0);

        // R6 address events
        addr_evt(1'b1, 1'b1); chk("R6 match read", int'(mode), 1);
        wr(8'h80); addr_evt(1'b1, 1'b0); chk("R6 match write", int'(mode), 0);
        addr_evt(1'b0, 1'b1); chk("R6 mismatch", int'(mode), 0);
        wr(8'hA0); addr_evt(1'b1, 1'b1); chk("R6 master ignores", int'(mode), 2);

        // R7 hardware beats software in the same cycle
        wr(8'hB0);
        arb_lost = 1'b1; wr(8'hF5); arb_lost = 1'b0;
        chk("R7 arb vs write", int'(rd_data), 'hC5);
        wr(8'h00);
        addr_done = 1'b1; addr_match = 1'b1; addr_rw = 1'b1;
        wr(8'hA7);
        addr_done = 1'b0; addr_match = 1'b0; addr_rw = 1'b0;
        chk("R7 addr vs write", int'(rd_data), 'h97);

        // R8 reception hold
        wr(8'hC0);
        rxd_read = 1'b1; cyc(); rxd_read = 1'b0;
        chk("R8 blocked", int'(rx_next_en), 0);
        repeat (3) cyc();
        chk("R8 still blocked", int'(rx_next_en), 0);
        wr(8'h80); chk("R8 release pending", int'(rx_next_en), 0);
        cyc(); chk("R8 released", int'(rx_next_en), 1);
        rxd_read = 1'b1; cyc(); rxd_read = 1'b0;
        chk("R8 hold clear no block", int'(rx_next_en), 1);
        wr(8'hD0);
        rxd_read = 1'b1; cyc(); rxd_read = 1'b0;
        chk("R8 transmit no block", int'(rx_next_en), 1);

        repeat (2) cyc();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule